// File: doc/BRIEF.md
# Lockstep Pair Fault Supervisor

This block watches a pair of processors that execute the same program in lockstep. On every cycle it compares the two output buses, and it merges the result with fault flags raised by neighbouring interface blocks. It then drives a recovery sequence. The first fault asks the host for a rollback or restart. A second fault that arrives soon after the host reports recovery complete is a recurrence. Depending on a configuration bit, a recurrence either stops the pair for good or carries on with the one processor that has not been flagged.

Each processor output is a valid-qualified stream that the block only observes. There is no ready signal and no back-pressure: the supervisor never stalls either processor, and a beat counts in the cycle its valid is sampled. The other pins are plain levels. All outputs come from registers and change on the clock edge that samples the cause.

Top module: `lfs_top`

## Requirements
- R1: During and after reset the block is in normal lockstep operation: `recov_req`=0, `halt`=0, `out_en`=1, `proc_sel`=2'b11 (bit 0 is processor A, bit 1 is processor B) and `fault_status`=0.
- R2: In normal or retry operation, a cycle where both valids are high and the data words differ is a fault. Equal data with both valids high is not a fault. Differing data with both valids low is not a fault.
- R3: In normal or retry operation, a cycle where exactly one of the two valids is high is a fault.
- R4: Any set bit of `ext_fault` is a fault in every state. In normal operation a fault raises `recov_req` on the next edge. `recov_req` then stays high, and all faults are ignored for the state decision, until `recov_done` is sampled high. That edge drops `recov_req` and opens the retry window.
- R5: The retry window lasts max(`win_len`,1) cycles, counted from the edge that samples `recov_done`. A fault inside the window is a recurrence. If the window runs out with no fault, the block returns to normal operation, and a later fault is handled as a first fault again (R4).
- R6: On a recurrence with `degrade_mode`=0, the block shuts down: `halt`=1, `out_en`=0, `proc_sel`=2'b00, `recov_req`=0. Only reset leaves this state.
- R7: On a recurrence with `degrade_mode`=1, if exactly one of `ext_fault[0]` (blames A) and `ext_fault[1]` (blames B) is set, the block keeps running on the other processor. `proc_sel` becomes 2'b10 when A is blamed and 2'b01 when B is blamed, with `halt`=0 and `out_en`=1.
- R8: On a recurrence with `degrade_mode`=1, if neither or both of `ext_fault[1:0]` are set, the block shuts down as in R6.
- R9: While running on one processor, compare faults and a flag blaming the idle processor have no effect. A flag blaming the active processor shuts the block down.
- R10: `fault_status` records the source of the first fault as a one-hot value: bit 0 is a data mismatch, bit 1 is a valid mismatch, and bit 2+k is `ext_fault[k]`. When several sources fire together, the lowest bit wins. The value holds until `status_clr`. A clear in the same cycle as a fault loads the new source. Compare sources are not recorded outside normal and retry operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | DATA_W | Processor A output word |
| a_valid | input | 1 | Processor A word valid |
| b_data | input | DATA_W | Processor B output word |
| b_valid | input | 1 | Processor B word valid |
| ext_fault | input | EXT_N | Fault flags from other blocks; bit 0 blames A, bit 1 blames B |
| recov_done | input | 1 | Host reports rollback or restart finished |
| degrade_mode | input | 1 | Recurrence response: 0 shut down, 1 single-processor |
| win_len | input | WIN_W | Recurrence window length in cycles |
| status_clr | input | 1 | Clears the first-fault record |
| recov_req | output | 1 | Rollback or restart request |
| halt | output | 1 | Stops both processors |
| out_en | output | 1 | Enables the module outputs |
| proc_sel | output | 2 | Processors in use (bit 0 A, bit 1 B) |
| fault_status | output | EXT_N+2 | One-hot first-fault source |

## Verification
The hardest case to reach from the ports is a recurrence that lands in the last cycle of the retry window. Right beside it is the same fault one cycle later, which counts as a fresh first fault. To reach both, the stimulus raises `recov_done` and then counts idle cycles before injecting the second fault, with `win_len` set to 0, 1 and 2 so that both sides of the edge are covered. The single-processor path needs the flag that blames one processor to arrive in the same cycle as the recurrence. The stimulus drives it alongside a data mismatch, then probes the degraded state with flags that blame each processor in turn.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_RECOVER  = 3'd1,
    ST_RETRY    = 3'd2,
    ST_DEGRADED = 3'd3,
    ST_SHUTDOWN = 3'd4
  } lfs_state_e;

  localparam int SRC_DATA  = 0;
  localparam int SRC_VALID = 1;
  localparam int SRC_EXT0  = 2;
endpackage

// File: rtl/lfs_compare.sv
module lfs_compare #(
  parameter int DATA_W = 16
) (
  input  logic              compare_en,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_valid,
  output logic              data_mis,
  output logic              valid_mis
);
  logic both_valid;
  logic word_diff;

  assign both_valid = a_valid & b_valid;
  assign word_diff  = |(a_data ^ b_data);
  assign data_mis   = compare_en & both_valid & word_diff;
  assign valid_mis  = compare_en & (a_valid ^ b_valid);
endmodule

// File: rtl/lfs_fault_merge.sv
module lfs_fault_merge #(
  parameter int EXT_N = 4,
  localparam int SRC_N = EXT_N + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_mis,
  input  logic             valid_mis,
  input  logic [EXT_N-1:0] ext_fault,
  input  logic             status_clr,
  output logic             fault_any,
  output logic [SRC_N-1:0] status
);
  import lfs_pkg::*;

  logic [SRC_N-1:0] src;
  logic [SRC_N-1:0] first_src;

  always_comb begin
    src            = '0;
    src[SRC_DATA]  = data_mis;
    src[SRC_VALID] = valid_mis;
    for (int k = 0; k < EXT_N; k++) src[SRC_EXT0 + k] = ext_fault[k];
  end

  assign fault_any = |src;

  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    first_src = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (src[i]) begin
        first_src    = '0;
        first_src[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              status <= '0;
    else if (fault_any && (status_clr || status == '0)) status <= first_src;
    else if (status_clr)                     status <= '0;
  end

  a_r10_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status));

  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0 && !status_clr) |=> $stable(status));
endmodule

// File: rtl/lfs_recovery_fsm.sv
module lfs_recovery_fsm #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_any,
  input  logic             flag_a,
  input  logic             flag_b,
  input  logic             recov_done,
  input  logic             degrade_mode,
  input  logic [WIN_W-1:0] win_len,
  output lfs_pkg::lfs_state_e state,
  output logic             compare_en,
  output logic             recov_req,
  output logic             halt,
  output logic             out_en,
  output logic [1:0]       proc_sel
);
  import lfs_pkg::*;

  lfs_state_e       state_nx;
  logic [WIN_W-1:0] win_cnt, win_cnt_nx;
  logic [1:0]       solo_q, solo_nx;
  logic             active_blamed;

  assign active_blamed = (solo_q[0] & flag_a) | (solo_q[1] & flag_b);

  always_comb begin
    state_nx   = state;
    win_cnt_nx = win_cnt;
    solo_nx    = solo_q;
    unique case (state)
      ST_RUN: if (fault_any) state_nx = ST_RECOVER;
      ST_RECOVER: if (recov_done) begin
        state_nx   = ST_RETRY;
        win_cnt_nx = win_len;
      end
      ST_RETRY: begin
        if (fault_any) begin
          if (degrade_mode && (flag_a ^ flag_b)) begin
            state_nx = ST_DEGRADED;
            solo_nx  = flag_a ? 2'b10 : 2'b01;
          end else begin
            state_nx = ST_SHUTDOWN;
          end
        end else if (win_cnt <= WIN_W'(1)) begin
          state_nx = ST_RUN;
        end else begin
          win_cnt_nx = win_cnt - WIN_W'(1);
        end
      end
      ST_DEGRADED: if (active_blamed) state_nx = ST_SHUTDOWN;
      default: state_nx = ST_SHUTDOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      win_cnt <= '0;
      solo_q  <= 2'b11;
    end else begin
      state   <= state_nx;
      win_cnt <= win_cnt_nx;
      solo_q  <= solo_nx;
    end
  end

  assign compare_en = (state == ST_RUN) || (state == ST_RETRY);
  assign recov_req  = (state == ST_RECOVER);
  assign halt       = (state == ST_SHUTDOWN);
  assign out_en     = !halt;
  assign proc_sel   = halt ? 2'b00 : (state == ST_DEGRADED) ? solo_q : 2'b11;

  a_r6_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUTDOWN) |=> (state == ST_SHUTDOWN));

  a_r4_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER && !recov_done) |=> (state == ST_RECOVER));

  a_r7_single_processor: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEGRADED) |-> ($countones(proc_sel) == 1));

  a_r9_choice_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEGRADED) |=> (state == ST_SHUTDOWN || $stable(proc_sel)));
endmodule

// File: rtl/lfs_top.sv
module lfs_top #(
  parameter int DATA_W = 16,
  parameter int EXT_N  = 4,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_valid,
  input  logic [EXT_N-1:0]  ext_fault,
  input  logic              recov_done,
  input  logic              degrade_mode,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              status_clr,
  output logic              recov_req,
  output logic              halt,
  output logic              out_en,
  output logic [1:0]        proc_sel,
  output logic [EXT_N+1:0]  fault_status
);
  import lfs_pkg::*;

  lfs_state_e state;
  logic       compare_en;
  logic       data_mis;
  logic       valid_mis;
  logic       fault_any;

  lfs_compare #(.DATA_W(DATA_W)) i_compare (
    .compare_en (compare_en),
    .a_data     (a_data),
    .a_valid    (a_valid),
    .b_data     (b_data),
    .b_valid    (b_valid),
    .data_mis   (data_mis),
    .valid_mis  (valid_mis)
  );

  lfs_fault_merge #(.EXT_N(EXT_N)) i_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_mis   (data_mis),
    .valid_mis  (valid_mis),
    .ext_fault  (ext_fault),
    .status_clr (status_clr),
    .fault_any  (fault_any),
    .status     (fault_status)
  );

  lfs_recovery_fsm #(.WIN_W(WIN_W)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_any    (fault_any),
    .flag_a       (ext_fault[0]),
    .flag_b       (ext_fault[1]),
    .recov_done   (recov_done),
    .degrade_mode (degrade_mode),
    .win_len      (win_len),
    .state        (state),
    .compare_en   (compare_en),
    .recov_req    (recov_req),
    .halt         (halt),
    .out_en       (out_en),
    .proc_sel     (proc_sel)
  );

  a_r2_match_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!recov_req && !halt && proc_sel == 2'b11 && a_valid && b_valid &&
     a_data == b_data && ext_fault == '0) |=> (!recov_req && !halt));

  a_r6_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> (!out_en && proc_sel == 2'b00 && !recov_req));
endmodule

// File: tb/test_lfs_top.sv
module test_lfs_top;
  localparam int DATA_W = 16;
  localparam int EXT_N  = 4;
  localparam int WIN_W  = 8;
  localparam int SW     = EXT_N + 2;

  typedef struct {
    logic          req;
    logic          hlt;
    logic          oe;
    logic [1:0]    sel;
    logic [SW-1:0] st;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] a_data, b_data;
  logic a_valid, b_valid;
  logic [EXT_N-1:0] ext_fault;
  logic recov_done, degrade_mode, status_clr;
  logic [WIN_W-1:0] win_len;
  logic recov_req, halt, out_en;
  logic [1:0] proc_sel;
  logic [SW-1:0] fault_status;

  // staged stimulus, applied at the next falling edge
  logic [DATA_W-1:0] s_ad, s_bd;
  logic s_av, s_bv, s_done, s_clr;
  logic [EXT_N-1:0] s_ext;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lfs_top #(.DATA_W(DATA_W), .EXT_N(EXT_N), .WIN_W(WIN_W)) i_lfs_top (
    .clk(clk), .rst_n(rst_n),
    .a_data(a_data), .a_valid(a_valid), .b_data(b_data), .b_valid(b_valid),
    .ext_fault(ext_fault), .recov_done(recov_done), .degrade_mode(degrade_mode),
    .win_len(win_len), .status_clr(status_clr),
    .recov_req(recov_req), .halt(halt), .out_en(out_en),
    .proc_sel(proc_sel), .fault_status(fault_status)
  );

  task automatic compare_out(input exp_t e);
    checks++;
    if (recov_req !== e.req || halt !== e.hlt || out_en !== e.oe ||
        proc_sel !== e.sel || fault_status !== e.st) begin
      errors++;
      $display("FAIL %s: got req=%b halt=%b oe=%b sel=%b st=%b, expected req=%b halt=%b oe=%b sel=%b st=%b",
               e.tag, recov_req, halt, out_en, proc_sel, fault_status,
               e.req, e.hlt, e.oe, e.sel, e.st);
    end
  endtask

  // monitor: one expected item per sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare_out(q.pop_front());
    end
  end

  task automatic stage_idle();
    s_ad = 16'h1234; s_bd = 16'h1234; s_av = 1'b1; s_bv = 1'b1;
    s_ext = '0; s_done = 1'b0; s_clr = 1'b0;
  endtask

  task automatic cyc(input logic req, input logic hlt, input logic oe,
                     input logic [1:0] sel, input logic [SW-1:0] st, input string tag);
    exp_t e;
    @(negedge clk);
    a_data = s_ad; b_data = s_bd; a_valid = s_av; b_valid = s_bv;
    ext_fault = s_ext; recov_done = s_done; status_clr = s_clr;
    e.req = req; e.hlt = hlt; e.oe = oe; e.sel = sel; e.st = st; e.tag = tag;
    q.push_back(e);
    stage_idle();
  endtask

  task automatic do_reset(input logic mode, input logic [WIN_W-1:0] win);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0;
    stage_idle();
    a_data = s_ad; b_data = s_bd; a_valid = s_av; b_valid = s_bv;
    ext_fault = s_ext; recov_done = 1'b0; status_clr = 1'b0;
    degrade_mode = mode; win_len = win;
    repeat (3) @(negedge clk);
    e.req = 1'b0; e.hlt = 1'b0; e.oe = 1'b1; e.sel = 2'b11; e.st = '0; e.tag = "R1 reset state";
    compare_out(e);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got no completion, expected end of stimulus");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    stage_idle();
    do_reset(1'b0, 8'd3);

    // R2: matching and invalid beats
    cyc(0, 0, 1, 2'b11, 6'b000000, "R2 equal valid data");
    s_av = 0; s_bv = 0; s_bd = 16'hBEEF;
    cyc(0, 0, 1, 2'b11, 6'b000000, "R2 differing data both invalid");
    s_bd = 16'h1235;
    cyc(1, 0, 1, 2'b11, 6'b000001, "R2 data mismatch starts recovery");
    s_bv = 0;
    cyc(1, 0, 1, 2'b11, 6'b000001, "R4 request held, compare ignored");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b000001, "R4 done drops request");
    cyc(0, 0, 1, 2'b11, 6'b000001, "R5 window cycle 1");
    cyc(0, 0, 1, 2'b11, 6'b000001, "R5 window cycle 2");
    cyc(0, 0, 1, 2'b11, 6'b000001, "R5 window cycle 3 expires");
    s_clr = 1; s_bv = 0;
    cyc(1, 0, 1, 2'b11, 6'b000010, "R3 valid mismatch is first fault after window, R10 clear+load");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b000010, "R4 done again");
    s_clr = 1;
    cyc(0, 0, 1, 2'b11, 6'b000000, "R10 clear without fault");
    s_bd = 16'h0000; s_ext = 4'b0100;
    cyc(0, 1, 0, 2'b00, 6'b000001, "R6 recurrence shuts down, R10 lowest source wins");
    s_clr = 1; s_done = 1;
    cyc(0, 1, 0, 2'b00, 6'b000000, "R6 shutdown is sticky");

    // degraded, window length 0 behaves as 1
    do_reset(1'b1, 8'd0);
    s_ext = 4'b0010;
    cyc(1, 0, 1, 2'b11, 6'b001000, "R4 external flag starts recovery");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b001000, "R4 done");
    s_ext = 4'b0001; s_bd = 16'h0F0F;
    cyc(0, 0, 1, 2'b10, 6'b001000, "R7 A blamed selects B");
    s_ext = 4'b0001; s_bd = 16'h0F0F; s_av = 0;
    cyc(0, 0, 1, 2'b10, 6'b001000, "R9 compare and idle-processor flag ignored");
    s_ext = 4'b0010;
    cyc(0, 1, 0, 2'b00, 6'b001000, "R9 active processor blamed shuts down");

    // bare mismatch recurrence on last window cycle
    do_reset(1'b1, 8'd2);
    s_bd = 16'h0001;
    cyc(1, 0, 1, 2'b11, 6'b000001, "R2 mismatch");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b000001, "R4 done");
    cyc(0, 0, 1, 2'b11, 6'b000001, "R5 window cycle 1");
    s_bd = 16'h0001;
    cyc(0, 1, 0, 2'b00, 6'b000001, "R8 bare mismatch on last window cycle shuts down");

    // window expiry then both flags
    do_reset(1'b1, 8'd1);
    s_ext = 4'b0001;
    cyc(1, 0, 1, 2'b11, 6'b000100, "R4 flag A starts recovery");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b000100, "R4 done");
    cyc(0, 0, 1, 2'b11, 6'b000100, "R5 one-cycle window expires");
    s_ext = 4'b0011;
    cyc(1, 0, 1, 2'b11, 6'b000100, "R5 fault after window is a first fault");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b000100, "R4 done");
    s_ext = 4'b0011;
    cyc(0, 1, 0, 2'b00, 6'b000100, "R8 both flags shut down");

    // select A
    do_reset(1'b1, 8'd4);
    s_ext = 4'b0010;
    cyc(1, 0, 1, 2'b11, 6'b001000, "R4 flag B starts recovery");
    s_done = 1;
    cyc(0, 0, 1, 2'b11, 6'b001000, "R4 done");
    s_ext = 4'b0010;
    cyc(0, 0, 1, 2'b01, 6'b001000, "R7 B blamed selects A");
    s_ext = 4'b0010; s_bd = 16'h5555;
    cyc(0, 0, 1, 2'b01, 6'b001000, "R9 idle B flagged, no effect");
    s_ext = 4'b0001;
    cyc(0, 1, 0, 2'b00, 6'b001000, "R9 active A blamed shuts down");

    @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule